// File: doc/BRIEF.md
# DMA Channel Address Stepping Unit

This block keeps the memory address registers of a two-channel DMA controller and moves them after each completed transfer. Each channel is divided into an A half and a B half. Every half has its own 24-bit address register and its own control word. The control word holds a transfer-size bit, a direction bit and a two-bit mode field. The A half's control word also carries a pairing bit, which joins the two halves of that channel into one wide channel.

Software loads control words and addresses through two write ports. The transfer engine reports each finished transfer with a strobe and a half select. On the clock edge that follows the strobe, the selected half's address steps by one or two, up or down. It stays put when the half is in idle mode. All addresses and all size bits are visible on the output ports at all times.

Top module: `dma_addr_step`

## Requirements
- R1: While reset is asserted and after it is released, every address reads 0 and every size bit reads 0 (byte size, increment, sequential mode, pairing off).
- R2: A control write stores cfg_wr_data into the half selected by cfg_wr_sel. The half select encoding is: bit 1 = channel, bit 0 = 1 for the B half. The control word layout is: bit 4 = size (1 word, 0 byte), bit 3 = direction (1 down, 0 up), bit 2 = pairing (used only when written to an A half), bits 1:0 = mode. The new size bit appears on word_o after the next edge.
- R3: An address write loads addr_wr_data into the selected half's 24-bit address register. The new value is visible after the next edge.
- R4: In sequential mode (00) and repeat mode (10) with direction 0, a strobe adds 1 for byte size or 2 for word size.
- R5: In sequential or repeat mode with direction 1, a strobe subtracts 1 for byte size or 2 for word size.
- R6: In idle mode (01), and in the reserved code 11, a strobe leaves the address unchanged.
- R7: Address arithmetic wraps modulo 2^24: incrementing past 0xFFFFFF and decrementing below 0 both wrap around.
- R8: With pairing off, the A and B halves of a channel step independently, each using its own control word.
- R9: With pairing on in a channel's A half, strobes that select that channel's B half have no effect. Strobes to the A half step it under the A half's control word.
- R10: If a control or address write targets the same half as a strobe in the same cycle, the write takes effect and the strobe's step is dropped. A write to a different half does not stop the strobe.
- R11: The stepped address is visible on addr_o one clock edge after the strobe. Strobes on back-to-back cycles each produce one step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Control word write enable |
| cfg_wr_sel | input | 2 | Half targeted by the control write |
| cfg_wr_data | input | 5 | Control word: size, direction, pairing, mode |
| addr_wr_en | input | 1 | Address write enable |
| addr_wr_sel | input | 2 | Half targeted by the address write |
| addr_wr_data | input | 24 | Address value to load |
| xfer_stb | input | 1 | Transfer-complete strobe |
| xfer_sel | input | 2 | Half that finished a transfer |
| addr_o | output | 96 | Current addresses, half h in bits [24h+23:24h] |
| word_o | output | 4 | Current size bit of each half |

## Verification
A corrupted control word or pairing bit does not show up until the next strobe to the affected half. At that point the address moves by the wrong amount, in the wrong direction, or when it should not move. The bench therefore follows every control change with strobes and compares all four addresses on every clock. Any fault in the step arithmetic, the wrap, or the priority between writes and strobes then shows up on addr_o one edge after the offending strobe.

// File: rtl/dma_step_pkg.sv
package dma_step_pkg;

    typedef enum logic [1:0] {
        MODE_SEQ  = 2'b00,
        MODE_IDLE = 2'b01,
        MODE_RPT  = 2'b10,
        MODE_RSVD = 2'b11
    } mode_e;

    // Per-half stored control (pairing is kept per channel, outside this struct)
    typedef struct packed {
        logic  word;
        logic  down;
        mode_e mode;
    } cfg_t;

    localparam int CFG_W = 5;

    function automatic logic mode_moves(mode_e m);
        return (m == MODE_SEQ) || (m == MODE_RPT);
    endfunction

endpackage

// File: rtl/dma_step_calc.sv
module dma_step_calc
    import dma_step_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  cfg_t              cfg_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [ADDR_W-1:0] next_o
);

    logic [ADDR_W-1:0] step;

    always_comb begin
        step = cfg_i.word ? ADDR_W'(2) : ADDR_W'(1);
        if (!mode_moves(cfg_i.mode)) begin
            next_o = addr_i;
        end else if (cfg_i.down) begin
            next_o = addr_i - step;
        end else begin
            next_o = addr_i + step;
        end
    end

endmodule

// File: rtl/dma_strobe_route.sv
module dma_strobe_route #(
    parameter int NUM_CH = 2,
    localparam int NUM_HALF = 2 * NUM_CH,
    localparam int SEL_W = $clog2(NUM_HALF)
) (
    input  logic                xfer_stb,
    input  logic [SEL_W-1:0]    xfer_sel,
    input  logic                cfg_wr_en,
    input  logic [SEL_W-1:0]    cfg_wr_sel,
    input  logic                addr_wr_en,
    input  logic [SEL_W-1:0]    addr_wr_sel,
    input  logic [NUM_CH-1:0]   pair_i,
    output logic [NUM_HALF-1:0] step_en_o
);

    for (genvar h = 0; h < NUM_HALF; h++) begin : g_half
        logic picked;
        logic wr_hit;
        logic blocked;

        assign picked  = xfer_stb && (xfer_sel == SEL_W'(h));
        assign wr_hit  = (cfg_wr_en  && (cfg_wr_sel  == SEL_W'(h))) ||
                         (addr_wr_en && (addr_wr_sel == SEL_W'(h)));
        if (h % 2 == 1) begin : g_b
            assign blocked = pair_i[h/2];
        end else begin : g_a
            assign blocked = 1'b0;
        end
        assign step_en_o[h] = picked && !wr_hit && !blocked;
    end

endmodule

// File: rtl/dma_addr_step.sv
module dma_addr_step
    import dma_step_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 24,
    localparam int NUM_HALF = 2 * NUM_CH,
    localparam int SEL_W = $clog2(NUM_HALF)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_wr_en,
    input  logic [SEL_W-1:0]           cfg_wr_sel,
    input  logic [CFG_W-1:0]           cfg_wr_data,
    input  logic                       addr_wr_en,
    input  logic [SEL_W-1:0]           addr_wr_sel,
    input  logic [ADDR_W-1:0]          addr_wr_data,
    input  logic                       xfer_stb,
    input  logic [SEL_W-1:0]           xfer_sel,
    output logic [NUM_HALF*ADDR_W-1:0] addr_o,
    output logic [NUM_HALF-1:0]        word_o
);

    typedef struct packed {
        logic [NUM_CH-1:0]                pair;
        cfg_t [NUM_HALF-1:0]              cfg;
        logic [NUM_HALF-1:0][ADDR_W-1:0]  addr;
    } state_t;

    state_t st_d, st_q;

    logic [NUM_HALF-1:0]             step_en;
    logic [NUM_HALF-1:0][ADDR_W-1:0] next_addr;
    cfg_t                            cfg_new;

    dma_strobe_route #(.NUM_CH(NUM_CH)) u_route (
        .xfer_stb    (xfer_stb),
        .xfer_sel    (xfer_sel),
        .cfg_wr_en   (cfg_wr_en),
        .cfg_wr_sel  (cfg_wr_sel),
        .addr_wr_en  (addr_wr_en),
        .addr_wr_sel (addr_wr_sel),
        .pair_i      (st_q.pair),
        .step_en_o   (step_en)
    );

    for (genvar h = 0; h < NUM_HALF; h++) begin : g_calc
        dma_step_calc #(.ADDR_W(ADDR_W)) u_calc (
            .cfg_i  (st_q.cfg[h]),
            .addr_i (st_q.addr[h]),
            .next_o (next_addr[h])
        );
        assign addr_o[h*ADDR_W +: ADDR_W] = st_q.addr[h];
        assign word_o[h]                  = st_q.cfg[h].word;
    end

    assign cfg_new = cfg_t'({cfg_wr_data[4:3], cfg_wr_data[1:0]});

    always_comb begin
        st_d = st_q;
        for (int h = 0; h < NUM_HALF; h++) begin
            if (step_en[h]) begin
                st_d.addr[h] = next_addr[h];
            end
            if (cfg_wr_en && (cfg_wr_sel == SEL_W'(h))) begin
                st_d.cfg[h] = cfg_new;
                if (h % 2 == 0) begin
                    st_d.pair[h/2] = cfg_wr_data[2];
                end
            end
            if (addr_wr_en && (addr_wr_sel == SEL_W'(h))) begin
                st_d.addr[h] = addr_wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/dma_addr_step_chk.sv
module dma_addr_step_chk
    import dma_step_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 24,
    localparam int NUM_HALF = 2 * NUM_CH,
    localparam int SEL_W = $clog2(NUM_HALF)
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            cfg_wr_en,
    input logic [SEL_W-1:0]                cfg_wr_sel,
    input logic [CFG_W-1:0]                cfg_wr_data,
    input logic                            addr_wr_en,
    input logic [SEL_W-1:0]                addr_wr_sel,
    input logic [ADDR_W-1:0]               addr_wr_data,
    input logic                            xfer_stb,
    input logic [SEL_W-1:0]                xfer_sel,
    input logic [NUM_HALF-1:0]             word_o,
    input logic [NUM_HALF-1:0][ADDR_W-1:0] addr_q,
    input cfg_t [NUM_HALF-1:0]             cfg_q,
    input logic [NUM_CH-1:0]               pair_q
);

    logic              cfg_hit, addr_hit, b_blk, moving;
    logic [ADDR_W-1:0] want;

    always_comb begin
        cfg_hit  = cfg_wr_en  && (cfg_wr_sel  == xfer_sel);
        addr_hit = addr_wr_en && (addr_wr_sel == xfer_sel);
        b_blk    = xfer_sel[0] && pair_q[xfer_sel[SEL_W-1:1]];
        moving   = (cfg_q[xfer_sel].mode == MODE_SEQ) || (cfg_q[xfer_sel].mode == MODE_RPT);
        if (cfg_q[xfer_sel].down) begin
            want = addr_q[xfer_sel] - (cfg_q[xfer_sel].word ? ADDR_W'(2) : ADDR_W'(1));
        end else begin
            want = addr_q[xfer_sel] + (cfg_q[xfer_sel].word ? ADDR_W'(2) : ADDR_W'(1));
        end
    end

    // R2
    p_word_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr_en |=> word_o[$past(cfg_wr_sel)] == $past(cfg_wr_data[4]));

    // R3
    p_addr_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        addr_wr_en |=> addr_q[$past(addr_wr_sel)] == $past(addr_wr_data));

    // R4, R5, R7, R11: magnitude, sign and wrap of one step
    p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_stb && !cfg_hit && !addr_hit && !b_blk && moving)
        |=> addr_q[$past(xfer_sel)] == $past(want));

    // R6
    p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_stb && !cfg_hit && !addr_hit && !moving)
        |=> addr_q[$past(xfer_sel)] == $past(addr_q[xfer_sel]));

    // R9
    p_b_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_stb && b_blk && !cfg_hit && !addr_hit)
        |=> addr_q[$past(xfer_sel)] == $past(addr_q[xfer_sel]));

    // R10
    p_write_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_stb && cfg_hit && !addr_hit)
        |=> addr_q[$past(xfer_sel)] == $past(addr_q[xfer_sel]));

endmodule

bind dma_addr_step dma_addr_step_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_wr_en    (cfg_wr_en),
    .cfg_wr_sel   (cfg_wr_sel),
    .cfg_wr_data  (cfg_wr_data),
    .addr_wr_en   (addr_wr_en),
    .addr_wr_sel  (addr_wr_sel),
    .addr_wr_data (addr_wr_data),
    .xfer_stb     (xfer_stb),
    .xfer_sel     (xfer_sel),
    .word_o       (word_o),
    .addr_q       (st_q.addr),
    .cfg_q        (st_q.cfg),
    .pair_q       (st_q.pair)
);

// File: tb/dma_addr_step_bench.sv
module dma_addr_step_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NH = 4;
    localparam int AW = 24;
    localparam int MODW = 1 << AW;

    logic           clk = 1'b0;
    logic           rst_n;
    logic           cfg_wr_en;
    logic [1:0]     cfg_wr_sel;
    logic [4:0]     cfg_wr_data;
    logic           addr_wr_en;
    logic [1:0]     addr_wr_sel;
    logic [AW-1:0]  addr_wr_data;
    logic           xfer_stb;
    logic [1:0]     xfer_sel;
    logic [NH*AW-1:0] addr_o;
    logic [NH-1:0]  word_o;

    int    checks = 0;
    int    fails  = 0;
    bit    done   = 0;
    string cur_req = "R1";

    int m_addr [NH];
    bit m_word [NH];
    bit m_down [NH];
    int m_mode [NH];
    bit m_pair [2];

    dma_addr_step u_dma_addr_step (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_wr_en    (cfg_wr_en),
        .cfg_wr_sel   (cfg_wr_sel),
        .cfg_wr_data  (cfg_wr_data),
        .addr_wr_en   (addr_wr_en),
        .addr_wr_sel  (addr_wr_sel),
        .addr_wr_data (addr_wr_data),
        .xfer_stb     (xfer_stb),
        .xfer_sel     (xfer_sel),
        .addr_o       (addr_o),
        .word_o       (word_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural reference, updated on the same edge as the design
    always @(posedge clk) begin
        int  s, stp;
        bit  blk, hit;
        if (!rst_n) begin
            for (int h = 0; h < NH; h++) begin
                m_addr[h] = 0; m_word[h] = 0; m_down[h] = 0; m_mode[h] = 0;
            end
            m_pair[0] = 0; m_pair[1] = 0;
        end else begin
            if (xfer_stb) begin
                s   = int'(xfer_sel);
                blk = (s % 2 == 1) && m_pair[s/2];
                hit = (cfg_wr_en && cfg_wr_sel == xfer_sel) ||
                      (addr_wr_en && addr_wr_sel == xfer_sel);
                stp = m_word[s] ? 2 : 1;
                if (!blk && !hit && (m_mode[s] == 0 || m_mode[s] == 2)) begin
                    if (m_down[s]) m_addr[s] = (m_addr[s] + MODW - stp) % MODW;
                    else           m_addr[s] = (m_addr[s] + stp) % MODW;
                end
            end
            if (cfg_wr_en) begin
                s = int'(cfg_wr_sel);
                m_word[s] = cfg_wr_data[4];
                m_down[s] = cfg_wr_data[3];
                m_mode[s] = int'(cfg_wr_data[1:0]);
                if (s % 2 == 0) m_pair[s/2] = cfg_wr_data[2];
            end
            if (addr_wr_en) m_addr[int'(addr_wr_sel)] = int'(addr_wr_data);
        end
    end

    // Compare every half on every falling edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            for (int h = 0; h < NH; h++) begin
                checks++;
                if (int'(addr_o[h*AW +: AW]) != m_addr[h]) begin
                    fails++;
                    $display("FAIL %s half %0d addr actual=%h expected=%h",
                             cur_req, h, addr_o[h*AW +: AW], m_addr[h]);
                end
                checks++;
                if (word_o[h] != m_word[h]) begin
                    fails++;
                    $display("FAIL %s half %0d word actual=%0d expected=%0d",
                             cur_req, h, word_o[h], m_word[h]);
                end
            end
        end
    end

    task automatic drive(input bit ce, input int cs, input int cd,
                         input bit ae, input int as, input int ad,
                         input bit xe, input int xs);
        @(posedge clk); #2;
        cfg_wr_en    = ce; cfg_wr_sel  = 2'(cs); cfg_wr_data  = 5'(cd);
        addr_wr_en   = ae; addr_wr_sel = 2'(as); addr_wr_data = AW'(ad);
        xfer_stb     = xe; xfer_sel    = 2'(xs);
    endtask

    task automatic wcfg(input int s, input int d);  drive(1, s, d, 0, 0, 0, 0, 0); endtask
    task automatic waddr(input int s, input int a); drive(0, 0, 0, 1, s, a, 0, 0); endtask
    task automatic strobe(input int s);             drive(0, 0, 0, 0, 0, 0, 1, s); endtask
    task automatic rest(input int n);
        for (int i = 0; i < n; i++) drive(0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        rst_n = 1'b0;
        cfg_wr_en = 0; cfg_wr_sel = 0; cfg_wr_data = 0;
        addr_wr_en = 0; addr_wr_sel = 0; addr_wr_data = 0;
        xfer_stb = 0; xfer_sel = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: outputs during reset
        checks++;
        if (addr_o != '0 || word_o != '0) begin
            fails++;
            $display("FAIL R1 reset actual=%h/%h expected=0/0", addr_o, word_o);
        end
        rst_n = 1'b1;
        cur_req = "R1"; rest(2);

        cur_req = "R3";
        waddr(0, 'h100000); waddr(1, 'h200000); waddr(2, 'h300000); waddr(3, 'h400000);
        rest(1);

        cur_req = "R2";
        wcfg(0, 'h10); wcfg(3, 'h10); wcfg(3, 'h0A); rest(1);

        cur_req = "R4";
        strobe(0); strobe(0); wcfg(1, 'h02); strobe(1); strobe(1); rest(1);

        cur_req = "R5";
        wcfg(2, 'h18); strobe(2); strobe(3); strobe(2); strobe(3); rest(1);

        cur_req = "R6";
        wcfg(0, 'h11); strobe(0); strobe(0); wcfg(0, 'h13); strobe(0); rest(1);

        cur_req = "R7";
        waddr(1, 'hFFFFFF); wcfg(1, 'h00); strobe(1);
        waddr(2, 'h000001); wcfg(2, 'h18); strobe(2);
        waddr(0, 'hFFFFFE); wcfg(0, 'h10); strobe(0); rest(1);

        cur_req = "R8";
        wcfg(0, 'h00); wcfg(1, 'h18);
        strobe(1); strobe(0); strobe(1); strobe(0); rest(1);

        cur_req = "R9";
        wcfg(2, 'h04); wcfg(3, 'h10);
        strobe(3); strobe(3); strobe(2); strobe(3); strobe(2);
        wcfg(2, 'h00); strobe(3); rest(1);

        cur_req = "R10";
        drive(0, 0, 0, 1, 0, 'hABCDEF, 1, 0);
        drive(1, 1, 'h10, 0, 0, 0, 1, 1);
        drive(0, 0, 0, 1, 2, 'h000010, 1, 0);
        drive(1, 3, 'h08, 0, 0, 0, 1, 1);
        rest(1);

        cur_req = "R11";
        wcfg(0, 'h02); wcfg(1, 'h1A);
        for (int i = 0; i < 6; i++) strobe(i % 2);
        rest(2);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule